// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block turns a 48-bit multiply-accumulate accumulator into a 32-bit value for a general register. It does this when a store-accumulator command is strobed. The accumulator is split into three fields:

- bits 47:40 are eight extension bits;
- bits 39:8 are the 32-bit signed fraction;
- bits 7:0 are eight guard bits below that fraction.

Seen as a 16-bit fraction, bits 39:24 are the value and bits 23:0 are its guard bits. A 16-bit fraction covers -1 to 1-2^-15, and a 32-bit fraction covers -1 to 1-2^-31.

Three mode inputs select the conversion:

- **Fractional enable.** When clear, the low 32 bits pass through unchanged as an integer.
- **Signed/unsigned select.** In fractional mode this chooses between a 32-bit fraction and a 16-bit fraction. The 16-bit fraction is always rounded to nearest even and is zero-extended into the upper half of the result.
- **Round enable.** For the 32-bit fraction this chooses rounding to nearest even instead of dropping the guard bits.

When rounding up would pass the most positive fraction, the result clamps to that value. The accumulator is only read, never written.

A two-state machine sequences the output. In `ST_IDLE`, no result is being presented. `ST_EMIT` is held for exactly one cycle after each store strobe.

| Transition | From | To | Condition |
|---|---|---|---|
| `GO_EMIT` | `ST_IDLE` | `ST_EMIT` | strobe high |
| `STAY_IDLE` | `ST_IDLE` | `ST_IDLE` | strobe low |
| `RE_EMIT` | `ST_EMIT` | `ST_EMIT` | strobe high (back-to-back store) |
| `BACK_IDLE` | `ST_EMIT` | `ST_IDLE` | strobe low |

The result register loads on the same edge that enters `ST_EMIT`. It holds its value at all other times.

Top module: `acc_readout_fmt`

## Requirements
- R1: While reset is asserted and right after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` is 1 in the cycle after a clock edge that samples `store_req` high, and 0 in the cycle after an edge that samples it low.
- R3: With `frac_en`=0, `rd_data` equals `acc_in[31:0]`, whatever `unsigned_sel` and `round_en` are.
- R4: With `frac_en`=1, `unsigned_sel`=0, `round_en`=0, `rd_data` equals `acc_in[39:8]`, and the guard bits 7:0 are dropped.
- R5: With `frac_en`=1, `unsigned_sel`=0, `round_en`=1, `rd_data` is `acc_in[39:8]` rounded by guard bits 7:0. If the guard bits are above 0x80 the value is incremented, and if they are below 0x80 it is kept. A negative value of all ones that rounds up becomes 0.
- R6: In the R5 mode, guard bits of exactly 0x80 increment the value only when bit 8 is 1, so the result's lsb becomes 0.
- R7: In the R5 mode, if `acc_in[39:8]` is 0x7FFF_FFFF and rounding would increment it, `rd_data` is 0x7FFF_FFFF.
- R8: With `frac_en`=1 and `unsigned_sel`=1, `rd_data[31:16]` is 0. `rd_data[15:0]` is `acc_in[39:24]` rounded to nearest by guard bits 23:0, and `round_en` has no effect.
- R9: In the R8 mode, guard bits of exactly 0x80_0000 increment the value only when bit 24 is 1.
- R10: In the R8 mode, if `acc_in[39:24]` is 0x7FFF and rounding would increment it, `rd_data` is 0x0000_7FFF.
- R11: `rd_data` changes only on an edge that samples `store_req` high. Accumulator or mode changes without a strobe leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_req | input | 1 | Store-accumulator strobe |
| acc_in | input | 48 | Accumulator contents |
| frac_en | input | 1 | 1 = fractional operands, 0 = integer |
| unsigned_sel | input | 1 | Fractional: 1 = 16-bit rounded result, 0 = 32-bit result |
| round_en | input | 1 | 32-bit fraction: 1 = round to nearest even, 0 = truncate |
| rd_valid | output | 1 | Result valid, one cycle per strobe |
| rd_data | output | 32 | Formatted register value |

## Verification
Each result is due one clock edge after the strobe. The edge that samples `store_req` high moves the state machine to `ST_EMIT` and loads `rd_data`, so `rd_valid` and `rd_data` are both correct in the following cycle.

The bench changes inputs on the falling edge and checks on the next falling edge, half a period after the loading edge. It then spends one more cycle without a strobe, with the accumulator and modes scrambled. At the falling edge of that cycle it checks that `rd_valid` has dropped and `rd_data` has held its value.

// File: rtl/acc_readout_fmt_pkg.sv
package acc_readout_fmt_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fmt_state_t;

    typedef enum logic [1:0] {
        FMT_INT       = 2'd0,
        FMT_F32_TRUNC = 2'd1,
        FMT_F32_RND   = 2'd2,
        FMT_F16_RND   = 2'd3
    } fmt_sel_t;

endpackage

// File: rtl/acc_mode_decode.sv
module acc_mode_decode
    import acc_readout_fmt_pkg::*;
(
    input  logic     frac_en,
    input  logic     unsigned_sel,
    input  logic     round_en,
    output fmt_sel_t fmt
);
    always_comb begin
        if (!frac_en)
            fmt = FMT_INT;
        else if (unsigned_sel)
            fmt = FMT_F16_RND;
        else if (round_en)
            fmt = FMT_F32_RND;
        else
            fmt = FMT_F32_TRUNC;
    end
endmodule

// File: rtl/acc_rne_round.sv
module acc_rne_round #(
    parameter int KEEP_W  = 32,
    parameter int GUARD_W = 8
) (
    input  logic [KEEP_W-1:0]  base,
    input  logic [GUARD_W-1:0] guard,
    output logic [KEEP_W-1:0]  rounded
);
    localparam logic [GUARD_W-1:0] HALF   = {1'b1, {(GUARD_W-1){1'b0}}};
    localparam logic [KEEP_W-1:0]  MAXPOS = {1'b0, {(KEEP_W-1){1'b1}}};
    localparam logic [KEEP_W-1:0]  ONE    = {{(KEEP_W-1){1'b0}}, 1'b1};

    logic bump;

    always_comb begin
        bump = (guard > HALF) || ((guard == HALF) && base[0]);
        if (bump && (base != MAXPOS))
            rounded = base + ONE;
        else
            rounded = base;
    end
endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
    import acc_readout_fmt_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int EXT_W  = 8,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              frac_en,
    input  logic              unsigned_sel,
    input  logic              round_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int FRAC_MSB = ACC_W - EXT_W - 1;
    localparam int G32_W    = ACC_W - EXT_W - WORD_W;
    localparam int G16_W    = ACC_W - EXT_W - HALF_W;

    fmt_state_t        state_q, state_d;
    fmt_sel_t          fmt;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] r32;
    logic [HALF_W-1:0] r16;
    logic              ext_unused;

    assign ext_unused = ^acc_in[ACC_W-1:FRAC_MSB+1];

    acc_mode_decode u_dec (
        .frac_en      (frac_en),
        .unsigned_sel (unsigned_sel),
        .round_en     (round_en),
        .fmt          (fmt)
    );

    acc_rne_round #(.KEEP_W(WORD_W), .GUARD_W(G32_W)) u_rnd32 (
        .base    (acc_in[FRAC_MSB:G32_W]),
        .guard   (acc_in[G32_W-1:0]),
        .rounded (r32)
    );

    acc_rne_round #(.KEEP_W(HALF_W), .GUARD_W(G16_W)) u_rnd16 (
        .base    (acc_in[FRAC_MSB:G16_W]),
        .guard   (acc_in[G16_W-1:0]),
        .rounded (r16)
    );

    always_comb begin
        unique case (fmt)
            FMT_INT:       word_d = acc_in[WORD_W-1:0];
            FMT_F32_TRUNC: word_d = acc_in[FRAC_MSB:G32_W];
            FMT_F32_RND:   word_d = r32;
            FMT_F16_RND:   word_d = {{(WORD_W-HALF_W){1'b0}}, r16};
            default:       word_d = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = store_req ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = store_req ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (store_req)
            rd_data <= word_d;
    end

    always_comb begin
        rd_valid = (state_q == ST_EMIT);
    end
endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk #(
    parameter int ACC_W  = 48,
    parameter int EXT_W  = 8,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_req,
    input logic [ACC_W-1:0]  acc_in,
    input logic              frac_en,
    input logic              unsigned_sel,
    input logic              round_en,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data
);
    localparam int FRAC_MSB = ACC_W - EXT_W - 1;
    localparam int G32_W    = ACC_W - EXT_W - WORD_W;
    localparam logic [WORD_W-1:0] MAX32 = {1'b0, {(WORD_W-1){1'b1}}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_data == '0));

    assert_valid_follows_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(store_req));

    assert_int_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !frac_en) |=> rd_data == $past(acc_in[WORD_W-1:0]));

    assert_trunc_drops_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && frac_en && !unsigned_sel && !round_en)
        |=> rd_data == $past(acc_in[FRAC_MSB:G32_W]));

    assert_clamp_max32_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && frac_en && !unsigned_sel && round_en
         && acc_in[FRAC_MSB:G32_W] == MAX32) |=> rd_data == MAX32);

    assert_half_zero_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && frac_en && unsigned_sel) |=> rd_data[WORD_W-1:HALF_W] == '0);

    assert_hold_without_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !store_req |=> $stable(rd_data));
endmodule

bind acc_readout_fmt acc_readout_fmt_chk #(
    .ACC_W(ACC_W), .EXT_W(EXT_W), .WORD_W(WORD_W), .HALF_W(HALF_W)
) u_chk (.*);

// File: tb/tb_acc_readout_fmt.sv
`timescale 1ns/1ps
module tb_acc_readout_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        store_req = 1'b0;
    logic [47:0] acc_in = '0;
    logic        frac_en = 1'b0;
    logic        unsigned_sel = 1'b0;
    logic        round_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acc_readout_fmt dut (
        .clk(clk), .rst_n(rst_n), .store_req(store_req), .acc_in(acc_in),
        .frac_en(frac_en), .unsigned_sel(unsigned_sel), .round_en(round_en),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] model(input logic [47:0] a, input bit f, u, r);
        logic [15:0] b16;
        logic [31:0] b32;
        if (!f) return a[31:0];
        if (u) begin
            b16 = a[39:24];
            if ((a[23:0] > 24'h80_0000 || (a[23:0] == 24'h80_0000 && b16[0]))
                && b16 != 16'h7FFF)
                b16 = b16 + 16'd1;
            return {16'h0000, b16};
        end
        b32 = a[39:8];
        if (!r) return b32;
        if ((a[7:0] > 8'h80 || (a[7:0] == 8'h80 && b32[0])) && b32 != 32'h7FFF_FFFF)
            b32 = b32 + 32'd1;
        return b32;
    endfunction

    function automatic string tag(input logic [47:0] a, input bit f, u, r);
        if (!f) return "R3";
        if (u) begin
            if (a[39:24] == 16'h7FFF) return "R10";
            if (a[23:0] == 24'h80_0000) return "R9";
            return "R8";
        end
        if (!r) return "R4";
        if (a[39:8] == 32'h7FFF_FFFF) return "R7";
        if (a[7:0] == 8'h80) return "R6";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [47:0] a, input bit f, input bit u, input bit r);
        logic [31:0] held;
        @(negedge clk);
        acc_in = a; frac_en = f; unsigned_sel = u; round_en = r; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        check(tag(a, f, u, r), rd_data, model(a, f, u, r));
        check("R2", {31'd0, rd_valid}, 32'd1);
        held = rd_data;
        acc_in = {$urandom, $urandom};
        frac_en = 1'($urandom); unsigned_sel = 1'($urandom); round_en = 1'($urandom);
        @(negedge clk);
        check("R2", {31'd0, rd_valid}, 32'd0);
        check("R11", rd_data, held);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", {31'd0, rd_valid}, 32'd0);
        check("R1", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 32'd0);

        // Integer passthrough (R3) with other mode bits set.
        issue(48'hAB_1234_5678_9A, 1'b0, 1'b1, 1'b1);
        // Truncation (R4).
        issue(48'h00_4000_0000_FF, 1'b1, 1'b0, 1'b0);
        // Round, below and above half (R5).
        issue(48'h00_1000_0000_7F, 1'b1, 1'b0, 1'b1);
        issue(48'h00_1000_0000_81, 1'b1, 1'b0, 1'b1);
        issue(48'hFF_FFFF_FFFF_90, 1'b1, 1'b0, 1'b1);
        // Ties (R6): even stays, odd goes up.
        issue(48'h00_1000_0002_80, 1'b1, 1'b0, 1'b1);
        issue(48'h00_1000_0003_80, 1'b1, 1'b0, 1'b1);
        // Clamp (R7).
        issue(48'h00_7FFF_FFFF_C0, 1'b1, 1'b0, 1'b1);
        // 16-bit round (R8): round_en ignored.
        issue(48'h00_1234_9000_00, 1'b1, 1'b1, 1'b0);
        issue(48'hFF_8001_0000_01, 1'b1, 1'b1, 1'b1);
        // 16-bit ties (R9).
        issue(48'h00_0004_8000_00, 1'b1, 1'b1, 1'b0);
        issue(48'h00_0005_8000_00, 1'b1, 1'b1, 1'b1);
        // 16-bit clamp (R10).
        issue(48'h00_7FFF_FFFF_FF, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 300; i++) begin
            logic [47:0] a;
            a = {$urandom, $urandom};
            case ($urandom % 5)
                0: a[7:0] = 8'h80;
                1: a[23:0] = 24'h80_0000;
                2: a[39:8] = 32'h7FFF_FFFF;
                default: ;
            endcase
            issue(a, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule